// File: doc/BRIEF.md
# Sector Check-Word Generator

This block computes the 16-bit check word that protects the data field of a floppy sector. The generator polynomial is x^16 + x^8 + 1. Payload bytes arrive on a byte-wide bus, one per clock, marked by a valid qualifier and by first-byte and final-byte strobes. The block needs no serial LFSR because it uses a byte-wide recurrence. At each byte, the low half of the register is XORed into both halves. The incoming byte goes into the high half, and the old high half goes into the low half. After the final payload byte, the block pushes one zero byte through the register on its own. It then presents the result together with a one-cycle done pulse.

Only the 512 data bytes of a sector are fed in; the address preamble is not. On the medium, the result follows the data with its high byte first. The block can also compare its result with a received check word and give a registered match flag. This makes it usable on both the write path and the read path.

A four-state controller sequences the work. IDLE waits for a first byte. ACCUM takes payload bytes. FLUSH absorbs the internal zero byte. REPORT raises done for one cycle. The transitions are:
- IDLE to ACCUM on a first byte that is not also the final byte.
- IDLE to FLUSH on a first byte that is also the final byte.
- ACCUM to ACCUM on any byte that is not the final byte. A first-byte strobe restarts the sum.
- ACCUM to FLUSH on the final byte.
- FLUSH to REPORT always.
- REPORT to IDLE always.

Top module: `sector_check_gen`

## Requirements
- R1: A byte accepted with `in_start` high is combined with an all-zero register, so any previous sum is discarded. A one-byte sector with value x therefore yields 16'h00xx.
- R2: Each accepted byte x changes the register y to {y[7:0]^x, y[7:0]^y[15:8]}. Bits 15:8 are the high byte, which is placed on the medium first.
- R3: After the byte with `in_last` high is accepted, one internal 0x00 byte is applied on the next cycle. `done` is high for exactly one cycle, in the second cycle after that final byte is accepted, and `chk_word` then holds the final value.
- R4: `chk_word` keeps the final value until the next byte accepted with `in_start`.
- R5: Cycles with `in_valid` low inside a sector leave the register unchanged, so stalls do not alter the result.
- R6: A byte with `in_start` high during ACCUM restarts the sum. Earlier bytes of the aborted sector have no effect.
- R7: In IDLE, bytes without `in_start` are ignored. During FLUSH and REPORT, all input bytes are ignored.
- R8: `cmp_en` is sampled with the first byte and `cmp_word` with the final byte. When `done` is high, `match` is 1 exactly if compare was enabled and the result equals the sampled word.
- R9: `match` is cleared by the next byte accepted with `in_start` and otherwise holds its value. It stays 0 for sectors run with compare disabled.
- R10: After reset, `chk_word` is 0, `done` is 0 and `match` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte on `in_data` is present this cycle |
| in_start | input | 1 | Present byte is the first of a sector |
| in_last | input | 1 | Present byte is the last payload byte |
| in_data | input | 8 | Payload byte |
| cmp_en | input | 1 | Enable compare for this sector (sampled with first byte) |
| cmp_word | input | 16 | Received check word (sampled with final byte) |
| chk_word | output | 16 | Check register; final result once `done` is seen |
| done | output | 1 | One-cycle pulse when the result is ready |
| match | output | 1 | Registered compare result, held until next start |

## Verification
The bench runs every one-byte sector value, where the result must be 16'h00xx. A design that skipped the flush byte, or did not clear on start, would return the byte in the high half or carry residue from earlier sectors. A sparse two-byte sweep and a full 512-byte sector with stalls check the recurrence in depth. A wrong stall handling would absorb bytes twice or absorb stale data. Further tests cover a restart in the middle of a sector, stray bytes while idle and during the flush, and the exact cycle of `done`. A design that took stray bytes, or pulsed `done` early, would give the wrong word at that cycle. The compare path is checked with equal and unequal words, and `match` is checked to hold over idle cycles and to clear on the next start.

// File: rtl/sck_pkg.sv
package sck_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_FLUSH,
        ST_REPORT
    } sck_state_e;
endpackage

// File: rtl/sck_step.sv
module sck_step #(
    parameter int BYTE_W = 8,
    localparam int CHK_W = 2 * BYTE_W
) (
    input  logic [CHK_W-1:0]  cur_i,
    input  logic [BYTE_W-1:0] din_i,
    input  logic              clr_i,
    output logic [CHK_W-1:0]  nxt_o
);
    logic [CHK_W-1:0]  base;
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;

    always_comb begin
        base  = clr_i ? '0 : cur_i;
        lo    = base[BYTE_W-1:0];
        hi    = base[CHK_W-1:BYTE_W];
        nxt_o = {lo ^ din_i, lo ^ hi};
    end
endmodule

// File: rtl/sck_fsm.sv
module sck_fsm
    import sck_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_i,
    input  logic       start_i,
    input  logic       last_i,
    output logic       take_o,
    output logic       clr_o,
    output logic       flush_o,
    output logic       done_o,
    output sck_state_e state_o
);
    sck_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (valid_i && start_i)
                    state_d = last_i ? ST_FLUSH : ST_ACCUM;
            end
            ST_ACCUM: begin
                if (valid_i && last_i) state_d = ST_FLUSH;
            end
            ST_FLUSH:  state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_o  = 1'b0;
        flush_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   take_o  = valid_i && start_i;
            ST_ACCUM:  take_o  = valid_i;
            ST_FLUSH:  flush_o = 1'b1;
            ST_REPORT: done_o  = 1'b1;
            default:   ;
        endcase
        clr_o   = take_o && start_i;
        state_o = state_q;
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3
    flush_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> done_o);
endmodule

// File: rtl/sck_cmp.sv
module sck_cmp #(
    parameter int BYTE_W = 8,
    localparam int CHK_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             begin_i,
    input  logic             cmp_en_i,
    input  logic             last_take_i,
    input  logic [CHK_W-1:0] cmp_word_i,
    input  logic             finish_i,
    input  logic [CHK_W-1:0] result_i,
    output logic             match_o
);
    logic             en_q;
    logic [CHK_W-1:0] word_q;
    logic             match_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            word_q  <= '0;
            match_q <= 1'b0;
        end else begin
            if (begin_i) begin
                en_q    <= cmp_en_i;
                match_q <= 1'b0;
            end
            if (last_take_i) word_q <= cmp_word_i;
            if (finish_i) match_q <= en_q && (result_i == word_q);
        end
    end

    assign match_o = match_q;

    // R9
    match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        begin_i |=> !match_o);
    // R8
    match_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> en_q);
endmodule

// File: rtl/sector_check_gen.sv
module sector_check_gen
    import sck_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CHK_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic              in_last,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              cmp_en,
    input  logic [CHK_W-1:0]  cmp_word,
    output logic [CHK_W-1:0]  chk_word,
    output logic              done,
    output logic              match
);
    logic              take, clr, flush;
    sck_state_e        state;
    logic [CHK_W-1:0]  chk_q, chk_nxt;
    logic [BYTE_W-1:0] step_din;

    sck_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .start_i (in_start),
        .last_i  (in_last),
        .take_o  (take),
        .clr_o   (clr),
        .flush_o (flush),
        .done_o  (done),
        .state_o (state)
    );

    assign step_din = flush ? '0 : in_data;

    sck_step #(.BYTE_W(BYTE_W)) u_step (
        .cur_i (chk_q),
        .din_i (step_din),
        .clr_i (clr),
        .nxt_o (chk_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              chk_q <= '0;
        else if (take || flush)  chk_q <= chk_nxt;
    end

    sck_cmp #(.BYTE_W(BYTE_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .begin_i     (clr),
        .cmp_en_i    (cmp_en),
        .last_take_i (take && in_last),
        .cmp_word_i  (cmp_word),
        .finish_i    (flush),
        .result_i    (chk_nxt),
        .match_o     (match)
    );

    assign chk_word = chk_q;

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(in_valid && in_start)) |=> $stable(chk_q));
    // R1
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (chk_q[BYTE_W-1:0] == '0));
    // R4
    report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(chk_q));
endmodule

// File: tb/sector_check_gen_tb.sv
module sector_check_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        cmp_en = 1'b0;
    logic [15:0] cmp_word = '0;
    logic [15:0] chk_word;
    logic        done, match;

    int nvec = 0;
    int nfail = 0;
    logic [7:0] pay [0:511];

    always #10 clk = ~clk;

    sector_check_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_data(in_data), .cmp_en(cmp_en),
        .cmp_word(cmp_word), .chk_word(chk_word), .done(done), .match(match)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R2 recurrence applied to the payload followed by one zero byte (R3)
    function automatic logic [15:0] ref_sum(input int len);
        logic [15:0] y = 16'h0;
        for (int i = 0; i <= len; i++) begin
            logic [7:0] x = (i < len) ? pay[i] : 8'h00;
            y = {y[7:0] ^ x, y[7:0] ^ y[15:8]};
        end
        return y;
    endfunction

    task automatic idle_in();
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_data = 8'h00;
    endtask

    task automatic send(input int len, input logic en, input logic [15:0] word,
                        input int gap, input logic junk, input string tag);
        logic [15:0] exp = ref_sum(len);
        for (int i = 0; i < len; i++) begin
            if (gap > 0 && i > 0 && (i % gap) == 0) begin
                @(negedge clk);
                in_valid = 1'b0; in_data = 8'hA5; in_start = 1'b1; in_last = 1'b1;
            end
            @(negedge clk);
            in_valid = 1'b1; in_data = pay[i];
            in_start = (i == 0); in_last = (i == len - 1);
            if (i == 0) cmp_en = en;
            if (i == len - 1) cmp_word = word;
        end
        @(negedge clk);
        idle_in();
        cmp_en = 1'b0; cmp_word = ~word;
        check({tag, " R3 done low in flush"}, {15'h0, done}, 16'h0);
        if (junk) begin
            in_valid = 1'b1; in_data = 8'h5A; in_start = 1'b1; in_last = 1'b1;
        end
        @(negedge clk);
        idle_in();
        check({tag, " R3 done pulse"}, {15'h0, done}, 16'h1);
        check({tag, " R2 R3 result"}, chk_word, exp);
        check({tag, " R8 match"}, {15'h0, match}, {15'h0, en && (exp == word)});
        @(negedge clk);
        check({tag, " R3 done one cycle"}, {15'h0, done}, 16'h0);
        check({tag, " R4 result held"}, chk_word, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset chk_word", chk_word, 16'h0);
        check("R10 reset done", {15'h0, done}, 16'h0);
        check("R10 reset match", {15'h0, match}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 one-byte sweep: result must be 16'h00xx; compare alternates
        for (int x = 0; x < 256; x++) begin
            pay[0] = 8'(x);
            check("R1 one-byte ref", ref_sum(1), {8'h00, 8'(x)});
            send(1, 1'b1, (x % 2 == 0) ? {8'h00, 8'(x)} : {8'h01, 8'(x)}, 0, 1'b0, "R1 sweep");
        end

        // R2 sparse two-byte sweep
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 13) begin
                pay[0] = 8'(a); pay[1] = 8'(b);
                send(2, 1'b0, 16'h0, 0, 1'b0, "R2 two-byte");
            end
        end

        // R5 full sector with stalls, compare equal then mismatched
        for (int i = 0; i < 512; i++) pay[i] = 8'((i * 37 + (i >> 3)) ^ 8'h6C);
        send(512, 1'b1, ref_sum(512), 7, 1'b0, "R5 sector stalls");
        // R9 match holds over idle cycles
        repeat (5) @(negedge clk);
        check("R9 match held", {15'h0, match}, 16'h1);
        send(512, 1'b1, ref_sum(512) ^ 16'h0100, 0, 1'b0, "R8 mismatch");

        // R9 start clears match; compare disabled keeps it low
        send(512, 1'b1, ref_sum(512), 0, 1'b0, "R9 set");
        @(negedge clk);
        in_valid = 1'b1; in_start = 1'b1; in_data = 8'h11; cmp_en = 1'b0;
        @(negedge clk);
        idle_in();
        check("R9 cleared by start", {15'h0, match}, 16'h0);
        check("R1 first byte", chk_word, 16'h1100);

        // R6 restart mid-sector: in ACCUM now; new start discards old bytes
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_start = 1'b0; in_data = 8'(i * 29 + 3);
        end
        pay[0] = 8'h3C; pay[1] = 8'hC3; pay[2] = 8'h81;
        send(3, 1'b0, 16'h0, 0, 1'b0, "R6 restart");
        check("R9 disabled compare", {15'h0, match}, 16'h0);

        // R7 stray bytes in idle without start
        held = chk_word;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_start = 1'b0; in_last = (i == 3); in_data = 8'(i + 200);
        end
        @(negedge clk);
        idle_in();
        check("R7 idle bytes ignored", chk_word, held);
        check("R7 no done from idle bytes", {15'h0, done}, 16'h0);

        // R7 bytes during flush ignored
        pay[0] = 8'h9E; pay[1] = 8'h47;
        send(2, 1'b1, ref_sum(2), 0, 1'b1, "R7 flush junk");

        repeat (3) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule